// File: doc/BRIEF.md
# External Static Memory Cycle Sequencer

This block times accesses to an asynchronous static memory bus that has several chip selects. A request names a chip select, a direction, an address and a set of byte enables. The block then drives the active-low chip select, read strobe, write strobe and byte-select lines for a fixed number of clocks. That span splits into a setup phase, a strobe (pulse) phase and a hold phase. The block raises a one-clock completion flag in the final clock of the access.

Reads and writes each have their own set of three timing codes: setup, pulse and total cycle length. A code is loaded with a single configuration strobe. Codes are kept in a compact non-linear form. The block expands them to clock counts when it accepts an access, and that access keeps those counts until it ends. When the next access goes to a different chip select than the one before it, the block inserts one clock in which every control line is high. This keeps two devices from driving the bus at once.

Neither the codes nor their combinations are checked. A pulse of zero, or a setup plus pulse longer than the cycle, gives undefined strobe timing.

Top module: `ext_sram_cycle_seq`

## Requirements
- R1: The setup code is 6 bits and expands to 128 × bit 5 + bits 4..0 clocks (0 to 159). The strobe goes low after exactly that many clocks of the access.
- R2: The pulse code is 7 bits and expands to 256 × bit 6 + bits 5..0 clocks (0 to 319). The strobe stays low for exactly that many consecutive clocks.
- R3: The cycle code is 9 bits and expands to 256 × bits 8..7 + bits 6..0 clocks (0 to 895). The access lasts exactly that many clocks, and a code of zero gives a single clock.
- R4: Reset clears all six timing codes to zero and leaves every control line high, with `req_ready` high and `acc_done` low. An access issued with zero codes lasts one clock and asserts no strobe.
- R5: During an access, chip select and byte-select lines are low on every clock. `mem_addr` carries the request address. The strobe is low on access clocks numbered from setup up to setup + pulse − 1, counting from 0.
- R6: A read uses the read code set and pulses only `mem_rd_n`. A write (`req_write` = 1) uses the write code set and pulses only `mem_we_n`. `cfg_for_write` = 1 loads the write set and 0 loads the read set.
- R7: `acc_done` is high for exactly one clock: the last clock of each access.
- R8: `req_ready` is high when the block is idle and in the last clock of an access, and low otherwise. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its first clock, or its gap clock, follows directly.
- R9: When an access targets a different chip select than the previous access, exactly one clock with all control lines high precedes it. An access to the same chip select that is taken in the last clock of the previous access follows it with no gap.
- R10: Chip select index i drives `mem_cs_n[i]` low. At most one chip select line is ever low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the three codes into one set |
| cfg_for_write | input | 1 | 1 selects the write set, 0 the read set |
| cfg_setup_code | input | 6 | Coded setup length |
| cfg_pulse_code | input | 7 | Coded strobe length |
| cfg_cycle_code | input | 9 | Coded total access length |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_cs | input | CS_W (2) | Chip select index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (24) | Access address |
| req_be | input | BE_W (4) | Byte enables, active high |
| mem_addr | output | ADDR_W (24) | Memory address bus |
| mem_cs_n | output | NUM_CS (4) | Chip selects, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | BE_W (4) | Byte selects, active low |
| acc_done | output | 1 | Last clock of the access |

## Verification
The hardest situation to produce is a request that is taken in the final clock of the previous access. Only that case separates the zero-gap same-chip-select path from the one-clock gap of a chip-select switch. An idle-to-busy start never exercises it. The stimulus keeps `req_valid` high with the next request queued while an access is still running, so the request is taken on the first edge where ready rises. Minimum codes (setup 0, pulse 1, cycle 1) then give single-clock accesses that run back to back, with the target switching between chip selects. The largest codes in each field, and codes with only the high-weight bit set, show whether the non-linear expansion lands the strobe edges on the right clocks.

// File: rtl/ext_sram_seq_pkg.sv
package ext_sram_seq_pkg;

    localparam int SETUP_CODE_W = 6;
    localparam int PULSE_CODE_W = 7;
    localparam int CYCLE_CODE_W = 9;
    localparam int CNT_W        = 10;
    localparam int NUM_SETS     = 2;
    localparam int SET_READ     = 0;
    localparam int SET_WRITE    = 1;

    typedef struct packed {
        logic [SETUP_CODE_W-1:0] setup;
        logic [PULSE_CODE_W-1:0] pulse;
        logic [CYCLE_CODE_W-1:0] cycle;
    } timing_code_t;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] pulse;
        logic [CNT_W-1:0] cycle;
    } timing_cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GAP    = 2'd1,
        ST_ACCESS = 2'd2
    } seq_state_e;

    function automatic logic [CNT_W-1:0] expand_setup(input logic [SETUP_CODE_W-1:0] c);
        logic [CNT_W-1:0] r;
        r = CNT_W'(c[4:0]);
        if (c[5]) r = r + CNT_W'(128);
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] expand_pulse(input logic [PULSE_CODE_W-1:0] c);
        logic [CNT_W-1:0] r;
        r = CNT_W'(c[5:0]);
        if (c[6]) r = r + CNT_W'(256);
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] expand_cycle(input logic [CYCLE_CODE_W-1:0] c);
        logic [CNT_W-1:0] r;
        r = CNT_W'(c[6:0]) + {c[8:7], 8'd0};
        return r;
    endfunction

endpackage

// File: rtl/ext_sram_cfg_store.sv
module ext_sram_cfg_store
    import ext_sram_seq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    for_write,
    input  logic [SETUP_CODE_W-1:0] setup_code,
    input  logic [PULSE_CODE_W-1:0] pulse_code,
    input  logic [CYCLE_CODE_W-1:0] cycle_code,
    output timing_code_t            codes [NUM_SETS]
);

    timing_code_t incoming;

    always_comb begin
        incoming.setup = setup_code;
        incoming.pulse = pulse_code;
        incoming.cycle = cycle_code;
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        localparam logic SEL = (s == SET_WRITE);
        timing_code_t held;
        always_ff @(posedge clk) begin
            if (rst) begin
                held <= '0;
            end else if (load && (for_write == SEL)) begin
                held <= incoming;
            end
        end
        assign codes[s] = held;
    end

endmodule

// File: rtl/ext_sram_timing_decode.sv
module ext_sram_timing_decode
    import ext_sram_seq_pkg::*;
(
    input  timing_code_t codes [NUM_SETS],
    input  logic         use_write,
    output timing_cnt_t  counts
);

    timing_cnt_t expanded [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_exp
        always_comb begin
            expanded[s].setup = expand_setup(codes[s].setup);
            expanded[s].pulse = expand_pulse(codes[s].pulse);
            expanded[s].cycle = expand_cycle(codes[s].cycle);
        end
    end

    always_comb begin
        counts = use_write ? expanded[SET_WRITE] : expanded[SET_READ];
    end

endmodule

// File: rtl/ext_sram_seq_engine.sv
module ext_sram_seq_engine
    import ext_sram_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int BE_W   = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CS_W-1:0]   req_cs,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  timing_cnt_t       sel_cnt,
    output logic              ready,
    output logic              last,
    output seq_state_e        state,
    output logic [CNT_W-1:0]  cnt,
    output timing_cnt_t       act_cnt,
    output logic [CS_W-1:0]   cur_cs,
    output logic              cur_write,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BE_W-1:0]   cur_be
);

    logic            have_prev;
    logic            accept;
    logic            need_gap;
    logic [CNT_W:0]  cnt_inc;

    always_comb begin
        cnt_inc  = {1'b0, cnt} + 1'b1;
        last     = (state == ST_ACCESS) && (cnt_inc >= {1'b0, act_cnt.cycle});
        ready    = (state == ST_IDLE) || last;
        accept   = req_valid && ready;
        need_gap = have_prev && (req_cs != cur_cs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            act_cnt   <= '0;
            have_prev <= 1'b0;
            cur_cs    <= '0;
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_be    <= '0;
        end else if (accept) begin
            state     <= need_gap ? ST_GAP : ST_ACCESS;
            cnt       <= '0;
            act_cnt   <= sel_cnt;
            have_prev <= 1'b1;
            cur_cs    <= req_cs;
            cur_write <= req_write;
            cur_addr  <= req_addr;
            cur_be    <= req_be;
        end else begin
            unique case (state)
                ST_GAP: begin
                    state <= ST_ACCESS;
                    cnt   <= '0;
                end
                ST_ACCESS: begin
                    if (last) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt_inc[CNT_W-1:0];
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/ext_sram_pin_drive.sv
module ext_sram_pin_drive
    import ext_sram_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int BE_W   = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  seq_state_e        state,
    input  logic [CNT_W-1:0]  cnt,
    input  timing_cnt_t       act_cnt,
    input  logic [CS_W-1:0]   cur_cs,
    input  logic              cur_write,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [BE_W-1:0]   cur_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_we_n,
    output logic [BE_W-1:0]   mem_be_n
);

    logic           in_access;
    logic           strobe;
    logic [CNT_W:0] strobe_end;

    always_comb begin
        in_access  = (state == ST_ACCESS);
        strobe_end = {1'b0, act_cnt.setup} + {1'b0, act_cnt.pulse};
        strobe     = in_access && (cnt >= act_cnt.setup) && ({1'b0, cnt} < strobe_end);
        mem_rd_n   = !(strobe && !cur_write);
        mem_we_n   = !(strobe && cur_write);
        mem_be_n   = in_access ? ~cur_be : '1;
        mem_addr   = cur_addr;
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign mem_cs_n[i] = !(in_access && (cur_cs == CS_W'(i)));
    end

endmodule

// File: rtl/ext_sram_cycle_seq.sv
module ext_sram_cycle_seq
    import ext_sram_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int BE_W   = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic              cfg_for_write,
    input  logic [5:0]        cfg_setup_code,
    input  logic [6:0]        cfg_pulse_code,
    input  logic [8:0]        cfg_cycle_code,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CS_W-1:0]   req_cs,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_we_n,
    output logic [BE_W-1:0]   mem_be_n,
    output logic              acc_done
);

    timing_code_t      codes [NUM_SETS];
    timing_cnt_t       sel_cnt;
    timing_cnt_t       act_cnt;
    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [CS_W-1:0]   cur_cs;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [BE_W-1:0]   cur_be;

    ext_sram_cfg_store u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load       (cfg_load),
        .for_write  (cfg_for_write),
        .setup_code (cfg_setup_code),
        .pulse_code (cfg_pulse_code),
        .cycle_code (cfg_cycle_code),
        .codes      (codes)
    );

    ext_sram_timing_decode u_dec (
        .codes     (codes),
        .use_write (req_write),
        .counts    (sel_cnt)
    );

    ext_sram_seq_engine #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W),
        .BE_W   (BE_W)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_cs    (req_cs),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .sel_cnt   (sel_cnt),
        .ready     (req_ready),
        .last      (acc_done),
        .state     (state),
        .cnt       (cnt),
        .act_cnt   (act_cnt),
        .cur_cs    (cur_cs),
        .cur_write (cur_write),
        .cur_addr  (cur_addr),
        .cur_be    (cur_be)
    );

    ext_sram_pin_drive #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W),
        .BE_W   (BE_W)
    ) u_pins (
        .state     (state),
        .cnt       (cnt),
        .act_cnt   (act_cnt),
        .cur_cs    (cur_cs),
        .cur_write (cur_write),
        .cur_addr  (cur_addr),
        .cur_be    (cur_be),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_rd_n  (mem_rd_n),
        .mem_we_n  (mem_we_n),
        .mem_be_n  (mem_be_n)
    );

endmodule

// File: rtl/ext_sram_cycle_seq_chk.sv
module ext_sram_cycle_seq_chk #(
    parameter int NUM_CS = 4,
    parameter int BE_W   = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [CS_W-1:0]   req_cs,
    input logic [NUM_CS-1:0] mem_cs_n,
    input logic              mem_rd_n,
    input logic              mem_we_n,
    input logic [BE_W-1:0]   mem_be_n,
    input logic              acc_done
);

    logic [NUM_CS-1:0] req_cs_n;
    logic              all_quiet;

    always_comb begin
        req_cs_n  = ~(NUM_CS'(1) << req_cs);
        all_quiet = (&mem_cs_n) && mem_rd_n && mem_we_n && (&mem_be_n);
    end

    // R10
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    // R5
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n || !mem_we_n) |-> !(&mem_cs_n));

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_we_n));

    // R7
    done_in_access_chk: assert property (@(posedge clk) disable iff (rst)
        acc_done |-> (!(&mem_cs_n) && req_ready));

    // R9
    switch_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_done && req_valid && (mem_cs_n != req_cs_n)) |=> all_quiet);

    // R9
    same_cs_nogap_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_done && req_valid && (mem_cs_n == req_cs_n)) |=> $stable(mem_cs_n));

    // R4
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (all_quiet && req_ready && !acc_done));

endmodule

bind ext_sram_cycle_seq ext_sram_cycle_seq_chk #(
    .NUM_CS (NUM_CS),
    .BE_W   (BE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_cs    (req_cs),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_we_n  (mem_we_n),
    .mem_be_n  (mem_be_n),
    .acc_done  (acc_done)
);

// File: tb/sim_ext_sram_cycle_seq.sv
module sim_ext_sram_cycle_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CS     = 4;
    localparam int ADDR_W     = 24;
    localparam int BE_W       = 4;
    localparam int CS_W       = 2;
    localparam int MAX_CYCLES = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_load = 1'b0;
    logic              cfg_for_write = 1'b0;
    logic [5:0]        cfg_setup_code = '0;
    logic [6:0]        cfg_pulse_code = '0;
    logic [8:0]        cfg_cycle_code = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [CS_W-1:0]   req_cs = '0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [BE_W-1:0]   req_be = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic [NUM_CS-1:0] mem_cs_n;
    logic              mem_rd_n;
    logic              mem_we_n;
    logic [BE_W-1:0]   mem_be_n;
    logic              acc_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_sram_cycle_seq u0 (.*);

    typedef struct {
        logic [NUM_CS-1:0] cs_n;
        logic              rd_n;
        logic              we_n;
        logic [BE_W-1:0]   be_n;
        logic              done;
        logic              chk_addr;
        logic [ADDR_W-1:0] addr;
    } exp_t;

    typedef struct {
        int                cs;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
    } req_t;

    exp_t exp_q[$];
    req_t pend_q[$];
    int   code_s[2], code_p[2], code_c[2];
    int   prev_cs = -1;
    int   tests = 0, fails = 0, cycles = 0;

    function automatic exp_t quiet();
        exp_t e;
        e.cs_n = '1; e.rd_n = 1'b1; e.we_n = 1'b1; e.be_n = '1;
        e.done = 1'b0; e.chk_addr = 1'b0; e.addr = '0;
        return e;
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic model_accept(input req_t r);
        int d, s, p, c, n;
        d = r.wr ? 1 : 0;
        s = ((code_s[d] >= 32) ? 128 : 0) + (code_s[d] % 32);
        p = ((code_p[d] >= 64) ? 256 : 0) + (code_p[d] % 64);
        c = (code_c[d] / 128) * 256 + (code_c[d] % 128);
        n = (c == 0) ? 1 : c;
        if (prev_cs >= 0 && prev_cs != r.cs) exp_q.push_back(quiet());
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e = quiet();
            e.cs_n = '1;
            e.cs_n[r.cs] = 1'b0;
            e.be_n = ~r.be;
            if (k >= s && k < s + p) begin
                if (r.wr) e.we_n = 1'b0; else e.rd_n = 1'b0;
            end
            e.done = (k == n - 1);
            e.chk_addr = 1'b1;
            e.addr = r.addr;
            exp_q.push_back(e);
        end
        prev_cs = r.cs;
    endtask

    task automatic step();
        exp_t e;
        logic exp_ready;
        @(negedge clk);
        cycles++;
        if (cycles > MAX_CYCLES) begin
            fails++; tests++;
            $display("FAIL watchdog: run exceeded %0d cycles", MAX_CYCLES);
            finish_run();
        end
        exp_ready = (exp_q.size() <= 1);
        e = (exp_q.size() > 0) ? exp_q[0] : quiet();
        tests++;
        if (mem_cs_n !== e.cs_n || mem_be_n !== e.be_n || req_ready !== exp_ready ||
            mem_rd_n !== e.rd_n || mem_we_n !== e.we_n || acc_done !== e.done ||
            (e.chk_addr && mem_addr !== e.addr)) begin
            fails++;
            if (mem_cs_n !== e.cs_n)
                $display("FAIL R5/R9/R10 cyc %0d cs_n got %b exp %b", cycles, mem_cs_n, e.cs_n);
            if (mem_be_n !== e.be_n)
                $display("FAIL R5 cyc %0d be_n got %b exp %b", cycles, mem_be_n, e.be_n);
            if (mem_rd_n !== e.rd_n || mem_we_n !== e.we_n)
                $display("FAIL R1/R2/R6 cyc %0d rd_n/we_n got %b%b exp %b%b",
                         cycles, mem_rd_n, mem_we_n, e.rd_n, e.we_n);
            if (acc_done !== e.done)
                $display("FAIL R3/R7 cyc %0d done got %b exp %b", cycles, acc_done, e.done);
            if (req_ready !== exp_ready)
                $display("FAIL R8 cyc %0d ready got %b exp %b", cycles, req_ready, exp_ready);
            if (e.chk_addr && mem_addr !== e.addr)
                $display("FAIL R5 cyc %0d addr got %h exp %h", cycles, mem_addr, e.addr);
        end
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        if (pend_q.size() > 0) begin
            req_valid = 1'b1;
            req_cs    = CS_W'(pend_q[0].cs);
            req_write = pend_q[0].wr;
            req_addr  = pend_q[0].addr;
            req_be    = pend_q[0].be;
            if (exp_ready) begin
                model_accept(pend_q[0]);
                void'(pend_q.pop_front());
            end
        end else begin
            req_valid = 1'b0;
        end
    endtask

    task automatic drain();
        while (pend_q.size() > 0 || exp_q.size() > 0) step();
        step();
    endtask

    task automatic load_set(input logic wr, input int s, input int p, input int c);
        drain();
        cfg_load = 1'b1; cfg_for_write = wr;
        cfg_setup_code = 6'(s); cfg_pulse_code = 7'(p); cfg_cycle_code = 9'(c);
        code_s[wr ? 1 : 0] = s; code_p[wr ? 1 : 0] = p; code_c[wr ? 1 : 0] = c;
        step();
        cfg_load = 1'b0;
    endtask

    task automatic push_req(input int cs, input logic wr, input int addr, input int be);
        req_t r;
        r.cs = cs; r.wr = wr; r.addr = ADDR_W'(addr); r.be = BE_W'(be);
        pend_q.push_back(r);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            code_s[d] = 0; code_p[d] = 0; code_c[d] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4: reset state, all lines high and ready
        repeat (3) step();
        // R4: zero codes give a one-clock access without strobe
        push_req(1, 1'b0, 24'h000100, 4'hF);
        drain();
        // R6: separate read and write sets
        load_set(1'b0, 3, 4, 10);
        load_set(1'b1, 1, 2, 5);
        // R8 R9: back-to-back same chip select, then switches
        push_req(1, 1'b0, 24'h012345, 4'h3);
        push_req(1, 1'b0, 24'h012346, 4'hC);
        push_req(1, 1'b1, 24'h0ABCDE, 4'h1);
        push_req(2, 1'b0, 24'h200000, 4'hF);
        push_req(0, 1'b1, 24'h300001, 4'h8);
        drain();
        // R1 R2 R3: high-weight code bits alone
        load_set(1'b0, 6'b100010, 7'b1000001, 9'b100000101);
        push_req(3, 1'b0, 24'h3FFFFF, 4'h5);
        drain();
        // R1 R2 R3: largest codes in every field
        load_set(1'b1, 63, 127, 511);
        load_set(1'b0, 63, 127, 511);
        push_req(1, 1'b1, 24'hFEDCBA, 4'hF);
        push_req(1, 1'b0, 24'h000001, 4'h2);
        drain();
        // R7 R8 R9 R10: single-clock accesses back to back with switches
        load_set(1'b0, 0, 1, 1);
        load_set(1'b1, 0, 1, 1);
        push_req(0, 1'b0, 24'h10, 4'h1);
        push_req(0, 1'b0, 24'h11, 4'h2);
        push_req(3, 1'b1, 24'h12, 4'h4);
        push_req(3, 1'b1, 24'h13, 4'h8);
        push_req(2, 1'b0, 24'h14, 4'hF);
        push_req(0, 1'b1, 24'h15, 4'h3);
        drain();
        // R5: hold phase present, cycle = 2 * 256 + 40
        load_set(1'b1, 5, 7, 9'b100101000);
        push_req(2, 1'b1, 24'h0F0F0F, 4'h6);
        drain();
        finish_run();
    end

endmodule